// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block carries out the processor-side work once an interrupt has been granted, and again when the handler returns. It holds the program counter, the status word and the interrupt stack pointer. An arbiter offers a request with a vector number, a level and a fast/normal flag. If the status word allows the request, the block saves the interrupted context. For a normal request it pushes the context onto the interrupt stack through a memory port. For a fast request it copies the context into two private backup registers. It then fetches the handler address from a relocatable 256-entry table of 4-byte words and rewrites the status word for handler execution.

A return command undoes an entry. A normal return pops the context from the stack. A fast return copies the backup registers back. Each of the four sequences has a fixed length, and a busy flag covers it. A load port stands in for ordinary instruction execution and sets the program counter, status word and stack pointer while the block is idle. A separate write port sets the table base.

Status word layout used throughout: bit 0 is the global interrupt enable, bit 1 selects the user stack, bit 2 is the privilege bit, and bits 7:4 hold the current level. All other bits pass through unchanged.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset, busy, req_ack, mem_we and mem_re are 0, and pc, psw and isp are all zero.
- R2: A request starts an entry only if the block is idle, psw bit 0 is 1 and req_level is strictly greater than psw[7:4]. Any other request leaves busy low and all state unchanged.
- R3: req_ack is high for exactly one cycle, which is the first cycle of each entry sequence. It is never high during a return.
- R4: busy is high for exactly 7 cycles for a normal entry, 5 for a fast entry, 6 for a normal return and 3 for a fast return. The count starts in the cycle after the accepting edge.
- R5: A normal entry makes exactly two memory writes. The old psw goes to isp-4 first, then the old pc goes to isp-8. The entry leaves isp reduced by 8.
- R6: A fast entry makes no memory write and leaves isp unchanged. It keeps the old pc and psw in backup registers.
- R7: Every entry reads the word at table base + 4 × req_vector, including vector 255. That word becomes the new pc.
- R8: After an entry, psw bits 0, 1 and 2 are 0 and psw[7:4] equals the accepted req_level. All other psw bits keep their pre-entry values.
- R9: A table base write stores base_wdata with its two low bits forced to 0. A base write in the same cycle as a table read only affects later reads.
- R10: A normal return reads pc from isp and then psw from isp+4. It restores both, adds 8 to isp and makes no memory write.
- R11: A fast return restores pc and psw from the backup registers. It makes no memory access.
- R12: While busy, new requests, return commands and loads are ignored. In an idle cycle a load beats a return, and a return beats an entry request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Arbiter offers a request |
| req_fast | input | 1 | Request uses the backup-register path |
| req_vector | input | 8 | Vector number of the request |
| req_level | input | 4 | Level of the request |
| req_ack | output | 1 | One-cycle pulse at the start of an entry |
| ret_valid | input | 1 | Return-from-interrupt command |
| ret_fast | input | 1 | Return uses the backup-register path |
| ld_en | input | 1 | Load pc, psw and isp (idle only) |
| ld_pc | input | 32 | Program counter to load |
| ld_psw | input | 32 | Status word to load |
| ld_isp | input | 32 | Interrupt stack pointer to load |
| base_we | input | 1 | Write the vector table base |
| base_wdata | input | 32 | New table base, low two bits dropped |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe, data returned next cycle |
| mem_addr | output | 32 | Byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, one cycle after mem_re |
| busy | output | 1 | A sequence is running |
| pc | output | 32 | Program counter |
| psw | output | 32 | Status word |
| isp | output | 32 | Interrupt stack pointer |

## Verification
Two pairs of operations can land on the same cycle. The first pair is a return command and an acceptable entry request arriving together while the block is idle. The bench raises both on one cycle and expects a 3-cycle fast return with no acknowledge. It then expects busy to stay low afterwards. The second pair is a table base write made in the exact cycle of the table read. The bench pokes the base in step 3 of a normal entry and expects the handler from the old base. A second entry then has to fetch from the new base.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  localparam int PSW_IE   = 0;
  localparam int PSW_USTK = 1;
  localparam int PSW_PRIV = 2;
  localparam int PSW_LVL  = 4;

  localparam int LEN_NENT = 7;
  localparam int LEN_FENT = 5;
  localparam int LEN_NRET = 6;
  localparam int LEN_FRET = 3;

  typedef enum logic [2:0] {
    OP_IDLE,
    OP_NENT,
    OP_FENT,
    OP_NRET,
    OP_FRET
  } op_e;
endpackage

// File: rtl/irq_seq_ctrl.sv
module irq_seq_ctrl
  import irq_seq_pkg::*;
#(
  parameter int STEP_W = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic req_fast,
  input  logic req_ok,
  input  logic ret_valid,
  input  logic ret_fast,
  input  logic ld_en,
  output op_e  op,
  output logic busy,
  output logic ack,
  output logic accept,
  output logic ld_take,
  output logic s_wr_psw,
  output logic s_wr_pc,
  output logic s_rd_vec,
  output logic s_cap_vec,
  output logic s_backup,
  output logic s_rd_pc,
  output logic s_rd_psw,
  output logic s_cap_psw,
  output logic s_commit
);
  op_e               op_q, op_d;
  logic [STEP_W-1:0] step_q, step_d, last;

  always_comb begin
    case (op_q)
      OP_NENT: last = STEP_W'(LEN_NENT - 1);
      OP_FENT: last = STEP_W'(LEN_FENT - 1);
      OP_NRET: last = STEP_W'(LEN_NRET - 1);
      OP_FRET: last = STEP_W'(LEN_FRET - 1);
      default: last = '0;
    endcase
  end

  assign busy = (op_q != OP_IDLE);

  always_comb begin
    op_d    = op_q;
    step_d  = step_q;
    accept  = 1'b0;
    ld_take = 1'b0;
    if (!busy) begin
      if (ld_en) begin
        ld_take = 1'b1;
      end else if (ret_valid) begin
        op_d   = ret_fast ? OP_FRET : OP_NRET;
        step_d = '0;
      end else if (req_valid && req_ok) begin
        op_d   = req_fast ? OP_FENT : OP_NENT;
        step_d = '0;
        accept = 1'b1;
      end
    end else if (step_q == last) begin
      op_d   = OP_IDLE;
      step_d = '0;
    end else begin
      step_d = step_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_IDLE;
      step_q <= '0;
    end else begin
      op_q   <= op_d;
      step_q <= step_d;
    end
  end

  assign op        = op_q;
  assign ack       = (op_q == OP_NENT || op_q == OP_FENT) && step_q == '0;
  assign s_wr_psw  = (op_q == OP_NENT) && step_q == STEP_W'(1);
  assign s_wr_pc   = (op_q == OP_NENT) && step_q == STEP_W'(2);
  assign s_rd_vec  = ((op_q == OP_NENT) && step_q == STEP_W'(3)) ||
                     ((op_q == OP_FENT) && step_q == STEP_W'(2));
  assign s_cap_vec = ((op_q == OP_NENT) && step_q == STEP_W'(4)) ||
                     ((op_q == OP_FENT) && step_q == STEP_W'(3));
  assign s_backup  = (op_q == OP_FENT) && step_q == STEP_W'(1);
  assign s_rd_pc   = (op_q == OP_NRET) && step_q == STEP_W'(0);
  assign s_rd_psw  = (op_q == OP_NRET) && step_q == STEP_W'(1);
  assign s_cap_psw = (op_q == OP_NRET) && step_q == STEP_W'(2);
  assign s_commit  = busy && (step_q == last);

  // R3
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);

  // R12
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !s_commit) |=> (busy && op_q == $past(op_q)));
endmodule

// File: rtl/irq_vec_base.sv
module irq_vec_base #(
  parameter int AW = 32,
  parameter int VW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          base_we,
  input  logic [AW-1:0] base_wdata,
  input  logic [VW-1:0] vec,
  output logic [AW-1:0] tbl_addr
);
  localparam logic [AW-1:0] ALIGN_MASK = ~AW'(3);

  logic [AW-1:0] base_q, base_d;

  always_comb begin
    base_d = base_q;
    if (base_we) base_d = base_wdata & ALIGN_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) base_q <= '0;
    else        base_q <= base_d;
  end

  assign tbl_addr = base_q + AW'({vec, 2'b00});
endmodule

// File: rtl/irq_seq_ctx.sv
module irq_seq_ctx
  import irq_seq_pkg::*;
#(
  parameter int AW = 32,
  parameter int VW = 8,
  parameter int LW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  op_e           op,
  input  logic          accept,
  input  logic          ld_take,
  input  logic          s_wr_psw,
  input  logic          s_wr_pc,
  input  logic          s_rd_vec,
  input  logic          s_cap_vec,
  input  logic          s_backup,
  input  logic          s_rd_pc,
  input  logic          s_rd_psw,
  input  logic          s_cap_psw,
  input  logic          s_commit,
  input  logic [VW-1:0] req_vector,
  input  logic [LW-1:0] req_level,
  input  logic [AW-1:0] ld_pc,
  input  logic [AW-1:0] ld_psw,
  input  logic [AW-1:0] ld_isp,
  input  logic [AW-1:0] tbl_addr,
  input  logic [AW-1:0] mem_rdata,
  output logic          req_ok,
  output logic [VW-1:0] lat_vec,
  output logic          mem_we,
  output logic          mem_re,
  output logic [AW-1:0] mem_addr,
  output logic [AW-1:0] mem_wdata,
  output logic [AW-1:0] pc,
  output logic [AW-1:0] psw,
  output logic [AW-1:0] isp
);
  localparam logic [AW-1:0] WORD  = AW'(4);
  localparam logic [AW-1:0] FRAME = AW'(8);

  logic [AW-1:0] pc_q, pc_d, psw_q, psw_d, isp_q, isp_d;
  logic [AW-1:0] bpc_q, bpc_d, bpsw_q, bpsw_d;
  logic [AW-1:0] hnd_q, hnd_d, rpc_q, rpc_d, rpsw_q, rpsw_d;
  logic [VW-1:0] vec_q, vec_d;
  logic [LW-1:0] lvl_q, lvl_d;
  logic [AW-1:0] ent_psw;
  logic          is_entry;

  assign req_ok   = psw_q[PSW_IE] && (req_level > psw_q[PSW_LVL +: LW]);
  assign is_entry = (op == OP_NENT) || (op == OP_FENT);

  always_comb begin
    ent_psw                = psw_q;
    ent_psw[PSW_IE]        = 1'b0;
    ent_psw[PSW_USTK]      = 1'b0;
    ent_psw[PSW_PRIV]      = 1'b0;
    ent_psw[PSW_LVL +: LW] = lvl_q;
  end

  always_comb begin
    pc_d   = pc_q;   psw_d  = psw_q;  isp_d  = isp_q;
    bpc_d  = bpc_q;  bpsw_d = bpsw_q;
    hnd_d  = hnd_q;  rpc_d  = rpc_q;  rpsw_d = rpsw_q;
    vec_d  = vec_q;  lvl_d  = lvl_q;
    if (ld_take) begin
      pc_d  = ld_pc;
      psw_d = ld_psw;
      isp_d = ld_isp;
    end
    if (accept) begin
      vec_d = req_vector;
      lvl_d = req_level;
    end
    if (s_backup) begin
      bpc_d  = pc_q;
      bpsw_d = psw_q;
    end
    if (s_cap_vec) hnd_d  = mem_rdata;
    if (s_rd_psw)  rpc_d  = mem_rdata;
    if (s_cap_psw) rpsw_d = mem_rdata;
    if (s_commit) begin
      case (op)
        OP_NENT: begin pc_d = hnd_q; psw_d = ent_psw; isp_d = isp_q - FRAME; end
        OP_FENT: begin pc_d = hnd_q; psw_d = ent_psw; end
        OP_NRET: begin pc_d = rpc_q; psw_d = rpsw_q; isp_d = isp_q + FRAME; end
        OP_FRET: begin pc_d = bpc_q; psw_d = bpsw_q; end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;  psw_q <= '0;  isp_q <= '0;
      bpc_q <= '0; bpsw_q <= '0;
      hnd_q <= '0; rpc_q <= '0;  rpsw_q <= '0;
      vec_q <= '0; lvl_q <= '0;
    end else begin
      pc_q <= pc_d;   psw_q <= psw_d;   isp_q <= isp_d;
      bpc_q <= bpc_d; bpsw_q <= bpsw_d;
      hnd_q <= hnd_d; rpc_q <= rpc_d;   rpsw_q <= rpsw_d;
      vec_q <= vec_d; lvl_q <= lvl_d;
    end
  end

  always_comb begin
    mem_addr  = '0;
    mem_wdata = '0;
    if (s_wr_psw) begin
      mem_addr  = isp_q - WORD;
      mem_wdata = psw_q;
    end else if (s_wr_pc) begin
      mem_addr  = isp_q - FRAME;
      mem_wdata = pc_q;
    end else if (s_rd_vec) begin
      mem_addr  = tbl_addr;
    end else if (s_rd_pc) begin
      mem_addr  = isp_q;
    end else if (s_rd_psw) begin
      mem_addr  = isp_q + WORD;
    end
  end

  assign mem_we  = s_wr_psw | s_wr_pc;
  assign mem_re  = s_rd_vec | s_rd_pc | s_rd_psw;
  assign lat_vec = vec_q;
  assign pc      = pc_q;
  assign psw     = psw_q;
  assign isp     = isp_q;

  // R2
  accept_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> psw_q[PSW_IE]);

  // R5
  nent_isp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_commit && op == OP_NENT) |=> (isp_q == $past(isp_q) - FRAME));

  // R6
  fast_nowr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_FENT || op == OP_FRET) |-> !mem_we);

  // R8
  ent_psw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_commit && is_entry) |=>
      (!psw_q[PSW_IE] && !psw_q[PSW_USTK] && !psw_q[PSW_PRIV]));

  // R9
  tbl_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_rd_vec |-> (mem_addr[1:0] == 2'b00));

  // R10
  nret_isp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_commit && op == OP_NRET) |=> (isp_q == $past(isp_q) + FRAME));
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_seq_pkg::*;
#(
  parameter int AW = 32,
  parameter int VW = 8,
  parameter int LW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_fast,
  input  logic [VW-1:0] req_vector,
  input  logic [LW-1:0] req_level,
  output logic          req_ack,
  input  logic          ret_valid,
  input  logic          ret_fast,
  input  logic          ld_en,
  input  logic [AW-1:0] ld_pc,
  input  logic [AW-1:0] ld_psw,
  input  logic [AW-1:0] ld_isp,
  input  logic          base_we,
  input  logic [AW-1:0] base_wdata,
  output logic          mem_we,
  output logic          mem_re,
  output logic [AW-1:0] mem_addr,
  output logic [AW-1:0] mem_wdata,
  input  logic [AW-1:0] mem_rdata,
  output logic          busy,
  output logic [AW-1:0] pc,
  output logic [AW-1:0] psw,
  output logic [AW-1:0] isp
);
  localparam int STEP_W = $clog2(LEN_NENT);

  op_e           op;
  logic          req_ok, accept, ld_take;
  logic          s_wr_psw, s_wr_pc, s_rd_vec, s_cap_vec, s_backup;
  logic          s_rd_pc, s_rd_psw, s_cap_psw, s_commit;
  logic [VW-1:0] lat_vec;
  logic [AW-1:0] tbl_addr;

  irq_seq_ctrl #(.STEP_W(STEP_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_fast(req_fast), .req_ok(req_ok),
    .ret_valid(ret_valid), .ret_fast(ret_fast), .ld_en(ld_en),
    .op(op), .busy(busy), .ack(req_ack), .accept(accept), .ld_take(ld_take),
    .s_wr_psw(s_wr_psw), .s_wr_pc(s_wr_pc), .s_rd_vec(s_rd_vec),
    .s_cap_vec(s_cap_vec), .s_backup(s_backup), .s_rd_pc(s_rd_pc),
    .s_rd_psw(s_rd_psw), .s_cap_psw(s_cap_psw), .s_commit(s_commit)
  );

  irq_vec_base #(.AW(AW), .VW(VW)) u_base (
    .clk(clk), .rst_n(rst_n),
    .base_we(base_we), .base_wdata(base_wdata),
    .vec(lat_vec), .tbl_addr(tbl_addr)
  );

  irq_seq_ctx #(.AW(AW), .VW(VW), .LW(LW)) u_ctx (
    .clk(clk), .rst_n(rst_n), .op(op), .accept(accept), .ld_take(ld_take),
    .s_wr_psw(s_wr_psw), .s_wr_pc(s_wr_pc), .s_rd_vec(s_rd_vec),
    .s_cap_vec(s_cap_vec), .s_backup(s_backup), .s_rd_pc(s_rd_pc),
    .s_rd_psw(s_rd_psw), .s_cap_psw(s_cap_psw), .s_commit(s_commit),
    .req_vector(req_vector), .req_level(req_level),
    .ld_pc(ld_pc), .ld_psw(ld_psw), .ld_isp(ld_isp),
    .tbl_addr(tbl_addr), .mem_rdata(mem_rdata),
    .req_ok(req_ok), .lat_vec(lat_vec),
    .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .pc(pc), .psw(psw), .isp(isp)
  );
endmodule

// File: tb/irq_entry_seq_bench.sv
module irq_entry_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_fast, ret_valid, ret_fast, ld_en, base_we;
  logic [7:0]  req_vector;
  logic [3:0]  req_level;
  logic [31:0] ld_pc, ld_psw, ld_isp, base_wdata;
  logic        req_ack, mem_we, mem_re, busy;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, pc, psw, isp;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  irq_entry_seq u_irq_entry_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_fast(req_fast), .req_vector(req_vector),
    .req_level(req_level), .req_ack(req_ack),
    .ret_valid(ret_valid), .ret_fast(ret_fast),
    .ld_en(ld_en), .ld_pc(ld_pc), .ld_psw(ld_psw), .ld_isp(ld_isp),
    .base_we(base_we), .base_wdata(base_wdata),
    .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .busy(busy), .pc(pc), .psw(psw), .isp(isp)
  );

  function automatic logic [31:0] hv(input logic [31:0] a);
    return 32'h5A00_0000 ^ a;
  endfunction

  // memory model with write and read logs
  logic [31:0] mem [1024];
  logic [31:0] wa [16];
  logic [31:0] wd [16];
  logic [31:0] ra [16];
  int wr_cnt, rd_cnt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 1024; i++) mem[i] <= hv(32'(i) * 4);
      wr_cnt    <= 0;
      rd_cnt    <= 0;
      mem_rdata <= '0;
    end else begin
      if (mem_we) begin
        mem[mem_addr[11:2]]  <= mem_wdata;
        wa[wr_cnt[3:0]]      <= mem_addr;
        wd[wr_cnt[3:0]]      <= mem_wdata;
        wr_cnt               <= wr_cnt + 1;
      end
      if (mem_re) begin
        mem_rdata            <= mem[mem_addr[11:2]];
        ra[rd_cnt[3:0]]      <= mem_addr;
        rd_cnt               <= rd_cnt + 1;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load(input logic [31:0] p_psw, input logic [31:0] p_pc, input logic [31:0] p_isp);
    @(negedge clk);
    ld_en = 1'b1; ld_psw = p_psw; ld_pc = p_pc; ld_isp = p_isp;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic set_base(input logic [31:0] b);
    @(negedge clk);
    base_we = 1'b1; base_wdata = b;
    @(negedge clk);
    base_we = 1'b0;
  endtask

  // kind: 0 none, 1 repeat request, 2 base write, 3 load
  task automatic run_seq(input bit is_ret, input bit both, input bit fast,
                         input logic [7:0] vec, input logic [3:0] lvl,
                         input int poke_at, input int kind, input logic [31:0] pdata,
                         output int cyc, output int acks);
    @(negedge clk);
    if (is_ret || both) begin ret_valid = 1'b1; ret_fast = fast; end
    if (!is_ret || both) begin
      req_valid = 1'b1; req_fast = fast; req_vector = vec; req_level = lvl;
    end
    @(negedge clk);
    ret_valid = 1'b0; req_valid = 1'b0;
    cyc = 0; acks = 0;
    while (busy && cyc < 20) begin
      if (req_ack) acks++;
      if (cyc == poke_at) begin
        case (kind)
          1: begin req_valid = 1'b1; req_fast = 1'b1; req_vector = 8'h09; req_level = 4'hF; end
          2: begin base_we = 1'b1; base_wdata = pdata; end
          3: begin ld_en = 1'b1; ld_pc = pdata; ld_psw = pdata; ld_isp = pdata; end
          default: ;
        endcase
      end
      cyc++;
      @(negedge clk);
      req_valid = 1'b0; base_we = 1'b0; ld_en = 1'b0;
    end
  endtask

  typedef struct packed {
    logic        fast;
    logic [7:0]  vec;
    logic [3:0]  lvl;
    logic [31:0] psw;
    logic [31:0] pc;
    logic [31:0] isp;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{1'b0, 8'h21, 4'd5,  32'hABCD_0037, 32'h0000_1234, 32'h0000_0F00},
    '{1'b1, 8'h7F, 4'd15, 32'h0000_00E1, 32'h2222_0000, 32'h0000_0E80},
    '{1'b0, 8'hFF, 4'd1,  32'h0000_0001, 32'h0000_4444, 32'h0000_0E00},
    '{1'b1, 8'h00, 4'd9,  32'hF0F0_0087, 32'h0000_5550, 32'h0000_0D00}
  };

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int cyc, acks, w0, r0;
    rst_n = 1'b0;
    req_valid = 0; req_fast = 0; req_vector = 0; req_level = 0;
    ret_valid = 0; ret_fast = 0; ld_en = 0; ld_pc = 0; ld_psw = 0; ld_isp = 0;
    base_we = 0; base_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", 32'(busy), 0);
    chk("R1 ack", 32'(req_ack), 0);
    chk("R1 mem_we", 32'(mem_we), 0);
    chk("R1 mem_re", 32'(mem_re), 0);
    chk("R1 pc", pc, 0);
    chk("R1 psw", psw, 0);
    chk("R1 isp", isp, 0);

    set_base(32'h0000_0400);

    for (int k = 0; k < 4; k++) begin
      vec_t v;
      logic [31:0] e_psw;
      v = VECS[k];
      e_psw = (v.psw & ~32'h0000_00F7) | (32'(v.lvl) << 4);
      load(v.psw, v.pc, v.isp);
      w0 = wr_cnt; r0 = rd_cnt;
      run_seq(1'b0, 1'b0, v.fast, v.vec, v.lvl, 99, 0, 0, cyc, acks);
      chk("R4 entry length", 32'(cyc), v.fast ? 32'd5 : 32'd7);
      chk("R3 ack count", 32'(acks), 1);
      if (v.fast) begin
        chk("R6 no writes", 32'(wr_cnt - w0), 0);
        chk("R6 isp kept", isp, v.isp);
      end else begin
        chk("R5 write count", 32'(wr_cnt - w0), 2);
        chk("R5 psw addr", wa[w0[3:0]], v.isp - 4);
        chk("R5 psw data", wd[w0[3:0]], v.psw);
        chk("R5 pc addr", wa[4'(w0 + 1)], v.isp - 8);
        chk("R5 pc data", wd[4'(w0 + 1)], v.pc);
        chk("R5 isp", isp, v.isp - 8);
      end
      chk("R7 table read addr", ra[r0[3:0]], 32'h400 + 4 * 32'(v.vec));
      chk("R7 handler pc", pc, hv(32'h400 + 4 * 32'(v.vec)));
      chk("R8 psw", psw, e_psw);
      w0 = wr_cnt; r0 = rd_cnt;
      run_seq(1'b1, 1'b0, v.fast, 0, 0, 99, 0, 0, cyc, acks);
      chk("R4 return length", 32'(cyc), v.fast ? 32'd3 : 32'd6);
      chk("R3 no ack on return", 32'(acks), 0);
      if (v.fast) begin
        chk("R11 no access", 32'(wr_cnt - w0 + rd_cnt - r0), 0);
        chk("R11 pc", pc, v.pc);
        chk("R11 psw", psw, v.psw);
      end else begin
        chk("R10 reads", 32'(rd_cnt - r0), 2);
        chk("R10 pc addr", ra[r0[3:0]], v.isp - 8);
        chk("R10 psw addr", ra[4'(r0 + 1)], v.isp - 4);
        chk("R10 no write", 32'(wr_cnt - w0), 0);
        chk("R10 pc", pc, v.pc);
        chk("R10 psw", psw, v.psw);
      end
      chk("R10 isp restored", isp, v.isp);
    end

    // R2 rejected: enable clear
    load(32'h0000_0030, 32'h100, 32'hC00);
    @(negedge clk); req_valid = 1; req_fast = 0; req_vector = 3; req_level = 15;
    @(negedge clk); req_valid = 0;
    chk("R2 enable off busy", 32'(busy), 0);
    repeat (2) @(negedge clk);
    chk("R2 enable off pc", pc, 32'h100);
    // R2 rejected: equal level, then one above
    load(32'h0000_0031, 32'h100, 32'hC00);
    @(negedge clk); req_valid = 1; req_fast = 0; req_vector = 3; req_level = 3;
    @(negedge clk); req_valid = 0;
    chk("R2 equal level busy", 32'(busy), 0);
    run_seq(1'b0, 1'b0, 1'b0, 8'h03, 4'd4, 99, 0, 0, cyc, acks);
    chk("R2 level above length", 32'(cyc), 7);

    // R12 request while busy is ignored
    load(32'h1, 32'h300, 32'hC00);
    run_seq(1'b0, 1'b0, 1'b0, 8'h05, 4'd2, 3, 1, 0, cyc, acks);
    chk("R12 busy request length", 32'(cyc), 7);
    chk("R12 busy request acks", 32'(acks), 1);
    chk("R12 busy request pc", pc, hv(32'h414));
    @(negedge clk);
    chk("R12 no late start", 32'(busy), 0);

    // R12 load while busy is ignored
    load(32'h1, 32'h300, 32'hC00);
    run_seq(1'b0, 1'b0, 1'b1, 8'h06, 4'd3, 2, 3, 32'hDEAD_BEE0, cyc, acks);
    chk("R12 busy load pc", pc, hv(32'h418));
    chk("R12 busy load isp", isp, 32'hC00);

    // R12 return beats request in the same idle cycle
    load(32'h1, 32'h500, 32'hC00);
    run_seq(1'b0, 1'b0, 1'b1, 8'h01, 4'd2, 99, 0, 0, cyc, acks);
    load(32'h1, 32'h777, 32'hC00);
    run_seq(1'b1, 1'b1, 1'b1, 8'h02, 4'd5, 99, 0, 0, cyc, acks);
    chk("R12 return wins length", 32'(cyc), 3);
    chk("R12 return wins acks", 32'(acks), 0);
    chk("R12 return wins pc", pc, 32'h500);
    @(negedge clk);
    chk("R12 request dropped", 32'(busy), 0);

    // R9 low bits dropped
    set_base(32'h0000_0803);
    load(32'h1, 32'h0, 32'hC00);
    run_seq(1'b0, 1'b0, 1'b0, 8'h02, 4'd1, 99, 0, 0, cyc, acks);
    chk("R9 aligned base", pc, hv(32'h808));
    // R9 base write in the table read cycle
    load(32'h1, 32'h0, 32'hC00);
    run_seq(1'b0, 1'b0, 1'b0, 8'h03, 4'd1, 3, 2, 32'h0000_0400, cyc, acks);
    chk("R9 same-cycle old base", pc, hv(32'h80C));
    load(32'h1, 32'h0, 32'hC00);
    run_seq(1'b0, 1'b0, 1'b0, 8'h03, 4'd1, 99, 0, 0, cyc, acks);
    chk("R9 new base later", pc, hv(32'h40C));

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule